// File: doc/BRIEF.md
# Dual-Format Serial Programming Port

This block is the slave serial port of a dual-loop frequency synthesizer. A host drives four lines: a serial clock, a main data line, an auxiliary data line and an enable line. All four are brought into the core clock domain through a synchronizer. The block shifts bits in on each rising edge of the serial clock, most significant bit first. When the enable line falls, the block moves the shifted word into one of three register groups. It drives the decoded fields on its outputs. Those fields feed the divider chains, phase detectors and power switches that sit outside this block.

The enable level during the shift sets the word class. With enable held high, the leading bit of the word picks a target. A leading 1 with eight bits loads the control fields. A leading 0 with thirty-two bits loads the reference and auxiliary divide ratios and the routing selects. With enable held low, the host clocks the channel ratios in and then pulses enable to commit them. A control bit sets whether those ratios arrive serially on the main line (thirty-two clocks) or in parallel on both lines (sixteen clocks). A transfer whose clock count does not fit its word class is dropped.

Top module: `serprog_top`

## Requirements
- R1: After reset, every output field is zero: normal mode, single-line channel loading, nothing powered down, all ratios and selects zero.
- R2: An enable-high transfer of exactly 8 clocks whose first bit is 1 loads the control fields at the falling edge of enable. Bits are sent MSB first, with word bit 7 as the identifier. The fields are: bit 6 test mode, bit 5 auxiliary data select, bit 4 reference-output divide-by-3 select, bit 3 transmit power-down, bit 2 receive power-down, bit 1 reference power-down. Bit 0 is unused.
- R3: An enable-high transfer of exactly 32 clocks whose first bit is 0 loads the reference fields at the falling edge of enable. With word bit 31 as the identifier, the fields are: bits 30:19 reference ratio, bits 18:5 auxiliary ratio, bit 4 first routing select, bit 3 second routing select, bit 2 auxiliary reference enable. Bits 1:0 are unused.
- R4: With auxiliary data select at 0, an enable-low transfer of exactly 32 clocks on the main line, committed by an enable pulse, sets the transmit ratio from the first 16 bits and the receive ratio from the last 16 bits. The auxiliary line has no effect.
- R5: With auxiliary data select at 1, an enable-low transfer of exactly 16 clocks sets the transmit ratio from the auxiliary line and the receive ratio from the main line. Both lines are sampled on the same clocks.
- R6: A channel-ratio load leaves the control and reference fields unchanged.
- R7: A transfer is discarded and all fields keep their values in each of these cases: the clock count does not match its word class, the identifier does not match the length, or a channel count does not suit the current auxiliary data select.
- R8: No output field changes while a transfer is still in progress. Fields change only after a falling edge of enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sClk | input | 1 | Serial clock; data sampled on its rising edge |
| sEnb | input | 1 | Enable line; its level picks the word class, its falling edge commits |
| sData | input | 1 | Main serial data line |
| sAux | input | 1 | Auxiliary serial data line (transmit ratio in two-line mode) |
| testMode | output | 1 | Counter test mode |
| auxDataSel | output | 1 | Two-line channel loading selected |
| refDiv3 | output | 1 | Reference output divide-by-3 select (0 selects divide-by-4) |
| txPowerDown | output | 1 | Transmit loop power-down |
| rxPowerDown | output | 1 | Receive loop power-down |
| refPowerDown | output | 1 | Reference counters power-down |
| refRatio | output | 12 | Reference divide ratio |
| auxRatio | output | 14 | Auxiliary reference divide ratio |
| fr1Sel1 | output | 1 | First reference routing select |
| fr1Sel2 | output | 1 | Second reference routing select |
| auxRefEn | output | 1 | Auxiliary reference counter enable |
| txRatio | output | 16 | Transmit channel divide ratio |
| rxRatio | output | 16 | Receive channel divide ratio |

## Verification
A miscounting bit counter or a wrong identifier decode shows up on the first commit after the fault. A valid word is then dropped, or a malformed word reaches the outputs. The field ports differ from the expected values within a few core cycles of the enable fall. A swapped line or a wrong shift order scrambles the ratio outputs at that same commit. A load strobe that fires at the wrong time changes a group the transfer should not touch. This includes control or reference fields changing during a channel load, and it shows at the ports within one cycle.

// File: rtl/serprog_pkg.sv
`timescale 1ns/1ps
package serprog_pkg;
  localparam int REF_W    = 12;
  localparam int AUX_W    = 14;
  localparam int CHAN_W   = 16;
  localparam int CTRL_LEN = 8;
  localparam int REF_LEN  = 32;
  localparam int CHAN_LEN = 2 * CHAN_W;
  localparam int CNT_W    = $clog2(REF_LEN + 1) + 1;

  typedef struct packed {
    logic shift;
    logic ldCtrl;
    logic ldRef;
    logic ldChan;
  } strobe_t;

  typedef struct packed {
    logic test;
    logic auxSel;
    logic refDiv3;
    logic txPd;
    logic rxPd;
    logic refPd;
  } ctrl_t;

  typedef struct packed {
    logic [REF_W-1:0] refRatio;
    logic [AUX_W-1:0] auxRatio;
    logic             sel1;
    logic             sel2;
    logic             auxEn;
  } ref_t;
endpackage

// File: rtl/serprog_ctrl.sv
`timescale 1ns/1ps
module serprog_ctrl
  import serprog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sClk,
  input  logic    sEnb,
  input  logic    headCtrl,
  input  logic    headRef,
  input  logic    auxSel,
  output strobe_t st
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [SYNC_STAGES-1:0] clkSync, enbSync;
  logic clkPrev, enbPrev;
  logic clkRise, enbRise, enbFall;
  logic [CNT_W-1:0] cnt, lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      enbSync <= '0;
      clkPrev <= 1'b0;
      enbPrev <= 1'b0;
    end else begin
      clkSync <= {clkSync[SYNC_STAGES-2:0], sClk};
      enbSync <= {enbSync[SYNC_STAGES-2:0], sEnb};
      clkPrev <= clkSync[SYNC_STAGES-1];
      enbPrev <= enbSync[SYNC_STAGES-1];
    end
  end

  assign clkRise = clkSync[SYNC_STAGES-1] & ~clkPrev;
  assign enbRise = enbSync[SYNC_STAGES-1] & ~enbPrev;
  assign enbFall = ~enbSync[SYNC_STAGES-1] & enbPrev;

  // cnt counts clocks of the current enable phase; lowCnt keeps the low-phase count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      lowCnt <= '0;
    end else if (enbRise) begin
      lowCnt <= cnt;
      cnt    <= '0;
    end else if (enbFall) begin
      cnt    <= '0;
    end else if (clkRise && cnt != CNT_W'(CNT_MAX)) begin
      cnt    <= cnt + 1'b1;
    end
  end

  logic chanLenOk;
  assign chanLenOk = auxSel ? (lowCnt == CNT_W'(CHAN_W)) : (lowCnt == CNT_W'(CHAN_LEN));

  always_comb begin
    st        = '0;
    st.shift  = clkRise;
    st.ldCtrl = enbFall && (cnt == CNT_W'(CTRL_LEN)) && headCtrl;
    st.ldRef  = enbFall && (cnt == CNT_W'(REF_LEN)) && !headRef;
    st.ldChan = enbFall && (cnt == '0) && chanLenOk;
  end
endmodule

// File: rtl/serprog_dp.sv
`timescale 1ns/1ps
module serprog_dp
  import serprog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sData,
  input  logic              sAux,
  input  strobe_t           st,
  output logic              headCtrl,
  output logic              headRef,
  output ctrl_t             ctrlQ,
  output ref_t              refQ,
  output logic [CHAN_W-1:0] txQ,
  output logic [CHAN_W-1:0] rxQ
);
  logic [SYNC_STAGES-1:0] dataSync, auxSync;
  logic [REF_LEN-1:0]     mainSr;
  logic [CHAN_W-1:0]      auxSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataSync <= '0;
      auxSync  <= '0;
      mainSr   <= '0;
      auxSr    <= '0;
    end else begin
      dataSync <= {dataSync[SYNC_STAGES-2:0], sData};
      auxSync  <= {auxSync[SYNC_STAGES-2:0], sAux};
      if (st.shift) begin
        mainSr <= {mainSr[REF_LEN-2:0], dataSync[SYNC_STAGES-1]};
        auxSr  <= {auxSr[CHAN_W-2:0], auxSync[SYNC_STAGES-1]};
      end
    end
  end

  assign headCtrl = mainSr[CTRL_LEN-1];
  assign headRef  = mainSr[REF_LEN-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      refQ  <= '0;
      txQ   <= '0;
      rxQ   <= '0;
    end else begin
      if (st.ldCtrl) ctrlQ <= mainSr[CTRL_LEN-2 -: $bits(ctrl_t)];
      if (st.ldRef)  refQ  <= mainSr[REF_LEN-2 -: $bits(ref_t)];
      if (st.ldChan) begin
        txQ <= ctrlQ.auxSel ? auxSr : mainSr[CHAN_LEN-1 -: CHAN_W];
        rxQ <= mainSr[CHAN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/serprog_top.sv
`timescale 1ns/1ps
module serprog_top
  import serprog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sClk,
  input  logic              sEnb,
  input  logic              sData,
  input  logic              sAux,
  output logic              testMode,
  output logic              auxDataSel,
  output logic              refDiv3,
  output logic              txPowerDown,
  output logic              rxPowerDown,
  output logic              refPowerDown,
  output logic [REF_W-1:0]  refRatio,
  output logic [AUX_W-1:0]  auxRatio,
  output logic              fr1Sel1,
  output logic              fr1Sel2,
  output logic              auxRefEn,
  output logic [CHAN_W-1:0] txRatio,
  output logic [CHAN_W-1:0] rxRatio
);
  strobe_t st;
  ctrl_t   ctrlQ;
  ref_t    refQ;
  logic    headCtrl, headRef;

  serprog_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sClk(sClk), .sEnb(sEnb),
    .headCtrl(headCtrl), .headRef(headRef), .auxSel(ctrlQ.auxSel), .st(st)
  );

  serprog_dp #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .sData(sData), .sAux(sAux), .st(st),
    .headCtrl(headCtrl), .headRef(headRef),
    .ctrlQ(ctrlQ), .refQ(refQ), .txQ(txRatio), .rxQ(rxRatio)
  );

  assign testMode     = ctrlQ.test;
  assign auxDataSel   = ctrlQ.auxSel;
  assign refDiv3      = ctrlQ.refDiv3;
  assign txPowerDown  = ctrlQ.txPd;
  assign rxPowerDown  = ctrlQ.rxPd;
  assign refPowerDown = ctrlQ.refPd;
  assign refRatio     = refQ.refRatio;
  assign auxRatio     = refQ.auxRatio;
  assign fr1Sel1      = refQ.sel1;
  assign fr1Sel2      = refQ.sel2;
  assign auxRefEn     = refQ.auxEn;
endmodule

// File: rtl/serprog_chk.sv
`timescale 1ns/1ps
module serprog_chk
  import serprog_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input strobe_t           st,
  input ctrl_t             ctrlQ,
  input ref_t              refQ,
  input logic [CHAN_W-1:0] txRatio,
  input logic [CHAN_W-1:0] rxRatio
);
  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.ldCtrl, st.ldRef, st.ldChan}));

  assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !st.ldCtrl |=> $stable(ctrlQ));

  assert_ref_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !st.ldRef |=> $stable(refQ));

  assert_chan_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !st.ldChan |=> $stable({txRatio, rxRatio}));

  assert_chan_keeps_ctrl_R6: assert property (@(posedge clk) disable iff (!rstN)
    st.ldChan |=> ($stable(ctrlQ) && $stable(refQ)));
endmodule

bind serprog_top serprog_chk uChk (
  .clk(clk), .rstN(rstN), .st(st), .ctrlQ(ctrlQ), .refQ(refQ),
  .txRatio(txRatio), .rxRatio(rxRatio)
);

// File: tb/tb_serprog_top.sv
`timescale 1ns/1ps
module tb_serprog_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sClk = 1'b0, sEnb = 1'b0, sData = 1'b0, sAux = 1'b0;
  logic testMode, auxDataSel, refDiv3, txPowerDown, rxPowerDown, refPowerDown;
  logic [11:0] refRatio;
  logic [13:0] auxRatio;
  logic fr1Sel1, fr1Sel2, auxRefEn;
  logic [15:0] txRatio, rxRatio;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  serprog_top dut (
    .clk(clk), .rstN(rstN), .sClk(sClk), .sEnb(sEnb), .sData(sData), .sAux(sAux),
    .testMode(testMode), .auxDataSel(auxDataSel), .refDiv3(refDiv3),
    .txPowerDown(txPowerDown), .rxPowerDown(rxPowerDown), .refPowerDown(refPowerDown),
    .refRatio(refRatio), .auxRatio(auxRatio), .fr1Sel1(fr1Sel1), .fr1Sel2(fr1Sel2),
    .auxRefEn(auxRefEn), .txRatio(txRatio), .rxRatio(rxRatio)
  );

  typedef struct packed {
    logic        hi;
    logic [5:0]  nbits;
    logic [31:0] mainW;
    logic [15:0] auxW;
    logic [5:0]  expCtrl;
    logic [28:0] expRef;
    logic [15:0] expTx;
    logic [15:0] expRx;
  } vec_t;

  localparam logic [28:0] REFV = {12'hABC, 14'h1234, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] REFW = {1'b0, REFV, 2'b11};
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd8,  32'h0000_00AA, 16'h0000, 6'h15, 29'h0,  16'h0000, 16'h0000}, // R2 two-line select
    '{1'b1, 6'd32, REFW,          16'h0000, 6'h15, REFV,   16'h0000, 16'h0000}, // R3
    '{1'b0, 6'd16, 32'h0000_5A5A, 16'hC3C3, 6'h15, REFV,   16'hC3C3, 16'h5A5A}, // R5 R6
    '{1'b1, 6'd8,  32'h0000_00CD, 16'h0000, 6'h26, REFV,   16'hC3C3, 16'h5A5A}, // R2 one-line select
    '{1'b0, 6'd32, 32'h1357_2468, 16'hFFFF, 6'h26, REFV,   16'h1357, 16'h2468}, // R4 aux ignored
    '{1'b0, 6'd16, 32'h0000_BEEF, 16'h0000, 6'h26, REFV,   16'h1357, 16'h2468}, // R7 short channel
    '{1'b1, 6'd8,  32'h0000_003F, 16'h0000, 6'h26, REFV,   16'h1357, 16'h2468}, // R7 id 0, 8 bits
    '{1'b1, 6'd32, 32'hFFFF_FFFF, 16'h0000, 6'h26, REFV,   16'h1357, 16'h2468}, // R7 id 1, 32 bits
    '{1'b1, 6'd12, 32'h0000_08FF, 16'h0000, 6'h26, REFV,   16'h1357, 16'h2468}, // R7 odd length
    '{1'b1, 6'd8,  32'h0000_0081, 16'h0000, 6'h00, REFV,   16'h1357, 16'h2468}  // R2 clear
  };

  function automatic logic [5:0] ctrlNow();
    return {testMode, auxDataSel, refDiv3, txPowerDown, rxPowerDown, refPowerDown};
  endfunction
  function automatic logic [28:0] refNow();
    return {refRatio, auxRatio, fr1Sel1, fr1Sel2, auxRefEn};
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic d, input logic a);
    sData = d;
    sAux = a;
    waitClk(4);
    sClk = 1'b1;
    waitClk(4);
    sClk = 1'b0;
  endtask

  task automatic sendWord(input logic hi, input int nbits, input logic [31:0] w, input logic [15:0] a);
    if (hi) begin
      sEnb = 1'b1;
      waitClk(4);
    end
    for (int i = nbits - 1; i >= 0; i--) clockBit(w[i], (i < 16) ? a[i] : 1'b0);
    waitClk(4);
    if (!hi) begin
      sEnb = 1'b1;
      waitClk(4);
    end
    sEnb = 1'b0;
    waitClk(10);
  endtask

  initial begin
    #500000ns;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    waitClk(5);
    // R1: reset state
    check("R1", "ctrl", 64'(ctrlNow()), 64'h0);
    check("R1", "ref", 64'(refNow()), 64'h0);
    check("R1", "chan", {32'h0, txRatio, rxRatio}, 64'h0);
    rstN = 1'b1;
    waitClk(5);

    for (int v = 0; v < NV; v++) begin
      sendWord(VECS[v].hi, int'(VECS[v].nbits), VECS[v].mainW, VECS[v].auxW);
      check("R2/R7 vector", $sformatf("ctrl v%0d", v), 64'(ctrlNow()), 64'(VECS[v].expCtrl));
      check("R3/R6 vector", $sformatf("ref v%0d", v), 64'(refNow()), 64'(VECS[v].expRef));
      check("R4/R5 vector", $sformatf("tx v%0d", v), 64'(txRatio), 64'(VECS[v].expTx));
      check("R4/R5 vector", $sformatf("rx v%0d", v), 64'(rxRatio), 64'(VECS[v].expRx));
    end

    // R8: a control word in flight leaves the outputs unchanged until enable falls
    sEnb = 1'b1;
    waitClk(4);
    for (int i = 7; i >= 0; i--) begin
      clockBit(((8'hFE >> i) & 8'h1) != 0, 1'b0);
      if (i == 4) check("R8", "ctrl mid-word", 64'(ctrlNow()), 64'h0);
    end
    waitClk(10);
    check("R8", "ctrl before enable falls", 64'(ctrlNow()), 64'h0);
    sEnb = 1'b0;
    waitClk(10);
    check("R8", "ctrl after enable falls", 64'(ctrlNow()), 64'h3F);

    // R8: channel bits clocked with enable low do nothing until the enable pulse
    for (int i = 15; i >= 0; i--) clockBit(1'b1, 1'b0);
    waitClk(10);
    check("R8", "tx before pulse", 64'(txRatio), 64'h1357);

    // R1: reset again clears everything
    rstN = 1'b0;
    waitClk(3);
    check("R1", "ctrl after reset", 64'(ctrlNow()), 64'h0);
    check("R1", "chan after reset", {32'h0, txRatio, rxRatio}, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule